// File: doc/BRIEF.md
# External interrupt sense controller

This block sits between six external interrupt request pins plus a non-maskable interrupt (NMI) pin and the rest of the interrupt logic. Each input first passes through a two-flop synchronizer. A 16-bit control register then chooses, for each request pin, whether a falling edge, a rising edge or a low level counts as a request. Edge requests are held in sticky flags until software clears them. Level requests follow the synchronized pin.

The four lowest pins can work in two ways, chosen at run time. They can be four independent request pins, or they can carry one 4-bit code that gives a priority level from 1 to 15. Two global rules can suppress requests. Every request can be hidden while the synchronized NMI pin is low. An NMI falling edge can be refused while the processor's block status bit is set or while the device is in standby. The block reports per-pin request flags, an encoded request level and a one-cycle NMI-accepted pulse.

Top module: `extint_sense_top`

## Requirements
- R1: The control register reads 0x4000 after the asynchronous reset `rstN` and after a cycle with `manualReset` high. Holding `standby` high leaves its contents unchanged.
- R2: A write stores `regWrData` into the register and a read returns it, except bit 12, which always reads 0 and ignores writes. Request pin i is controlled by the 2-bit field at bits 2i+1:2i.
- R3: The NMI pin and every request pin pass through two synchronizing flops. A level-detected change appears at the outputs after the second rising clock edge following the pin change.
- R4: Field code 00 (falling edge) sets the pin's request flag after the third rising edge following a high-to-low transition. The flag stays set after the pin returns high.
- R5: Field code 01 (rising edge) sets the pin's request flag after a low-to-high transition, with the same timing as R4, and the flag is sticky.
- R6: Field codes 10 and 11 (low level) make the request flag equal to the inverted synchronized pin, with no stickiness.
- R7: Pulsing `reqClear[i]` for one cycle clears the sticky flag of pin i at the next rising edge.
- R8: A register write that changes pin i's field clears that pin's sticky flag. A write that leaves the field unchanged keeps the flag.
- R9: When bit 14 is 1, pins 3..0 form a code v. `reqLevel` is 15 minus v, or 0 when v is 4'b1111, and `reqFlag[3:0]` is 0. When bit 14 is 0, `reqLevel` is 0 and pins 3..0 are independent requests.
- R10: When bit 15 is 1 and the synchronized NMI pin is low, `reqFlag` and `reqLevel` are all 0. When bit 15 is 0, a low NMI pin masks nothing.
- R11: After a falling NMI transition, `nmiAccept` is high for the single cycle that follows the second rising edge. It is suppressed while `blockStatus` is 1 and bit 13 is 0. When bit 13 is 1, `blockStatus` has no effect.
- R12: `nmiAccept` is suppressed while `standby` is 1 and bit 15 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| manualReset | input | 1 | Synchronous manual reset, active high |
| standby | input | 1 | Device is in standby |
| blockStatus | input | 1 | Processor block status bit |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 16 | Control register write data |
| regRdData | output | 16 | Control register read data |
| reqClear | input | 6 | Per-pin sticky flag clear strobes |
| irqPin | input | 6 | External request pins, asynchronous |
| nmiPin | input | 1 | External NMI pin, asynchronous, active low |
| reqFlag | output | 6 | Per-pin request flags |
| reqLevel | output | 4 | Encoded request level, 0 means none |
| nmiAccept | output | 1 | One-cycle pulse on an accepted NMI falling edge |

## Verification
Inputs are driven and outputs sampled on falling clock edges. Every latency is therefore counted in rising edges from the sample point:
- A register write or clear strobe shows after one rising edge.
- A level request, an encoded level or the NMI mask shows after two.
- A sticky edge flag shows after three.
- The NMI pulse is present after two rising edges and gone after three.

Each check waits exactly that many cycles. Where a one-cycle pulse or a first-appearance time matters, the value one cycle earlier is checked as well.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int NUM_PINS = 6;
  localparam int ENC_PINS = 4;
  localparam int REG_W = 16;
  localparam int FIELD_W = 2;
  localparam int BIT_MASKALL = 15;
  localparam int BIT_ENCMODE = 14;
  localparam int BIT_NMIOVR = 13;
  localparam int BIT_RSVD = 12;
  localparam logic [REG_W-1:0] RESET_VAL = 16'h4000;

  typedef enum logic [FIELD_W-1:0] {
    SENSE_FALL = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_LOW  = 2'b10,
    SENSE_RSVD = 2'b11
  } senseMode_t;

  typedef struct packed {
    logic [NUM_PINS-1:0]              modeClr;
    logic                             encMode;
    logic                             maskAll;
    logic                             nmiBlockOverride;
    logic [NUM_PINS-1:0][FIELD_W-1:0] sense;
  } ctlBus_t;
endpackage

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             manualReset,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output ctlBus_t          ctl
);
  localparam logic [REG_W-1:0] WR_MASK = ~(REG_W'(1) << BIT_RSVD);

  logic [REG_W-1:0] ctlReg;
  logic             wrAccepted;
  logic             encChange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctlReg <= RESET_VAL;
    else if (manualReset) ctlReg <= RESET_VAL;
    else if (regWrEn)     ctlReg <= regWrData & WR_MASK;
  end

  assign wrAccepted = regWrEn && !manualReset;
  assign encChange  = wrAccepted && (regWrData[BIT_ENCMODE] != ctlReg[BIT_ENCMODE]);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_field
    logic fieldChange;
    assign fieldChange =
      wrAccepted && (regWrData[FIELD_W*i +: FIELD_W] != ctlReg[FIELD_W*i +: FIELD_W]);
    if (i < ENC_PINS) begin : g_enc
      assign ctl.modeClr[i] = manualReset || fieldChange || encChange;
    end else begin : g_plain
      assign ctl.modeClr[i] = manualReset || fieldChange;
    end
    assign ctl.sense[i] = ctlReg[FIELD_W*i +: FIELD_W];
  end

  assign ctl.encMode          = ctlReg[BIT_ENCMODE];
  assign ctl.maskAll          = ctlReg[BIT_MASKALL];
  assign ctl.nmiBlockOverride = ctlReg[BIT_NMIOVR];
  assign regRdData            = ctlReg;
endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlBus_t             ctl,
  input  logic [NUM_PINS-1:0] irqPin,
  input  logic                nmiPin,
  input  logic [NUM_PINS-1:0] reqClear,
  input  logic                blockStatus,
  input  logic                standby,
  output logic [NUM_PINS-1:0] reqFlag,
  output logic [ENC_PINS-1:0] reqLevel,
  output logic                nmiAccept,
  output logic                nmiSyncLow
);
  localparam int ALL_W = NUM_PINS + 1;
  localparam int NMI_IDX = NUM_PINS;
  localparam logic [ENC_PINS-1:0] NO_REQ_CODE = '1;

  logic [ALL_W-1:0] syncA, syncB, prevB;
  logic             hideAll;
  logic             nmiFall, nmiBlocked;
  logic [ENC_PINS-1:0] code;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1;
      syncB <= '1;
      prevB <= '1;
    end else begin
      syncA <= {nmiPin, irqPin};
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign nmiSyncLow = !syncB[NMI_IDX];
  assign hideAll    = ctl.maskAll && nmiSyncLow;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    senseMode_t mode;
    logic isEdge, hit, encBlock, sticky, rawReq;
    assign mode   = senseMode_t'(ctl.sense[i]);
    assign isEdge = (mode == SENSE_FALL) || (mode == SENSE_RISE);
    assign hit    = (mode == SENSE_FALL) ? (prevB[i] && !syncB[i])
                                         : (!prevB[i] && syncB[i]);
    if (i < ENC_PINS) begin : g_enc
      assign encBlock = ctl.encMode;
    end else begin : g_plain
      assign encBlock = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                           sticky <= 1'b0;
      else if (ctl.modeClr[i])             sticky <= 1'b0;
      else if (isEdge && hit && !encBlock) sticky <= 1'b1;
      else if (reqClear[i])                sticky <= 1'b0;
    end

    assign rawReq     = isEdge ? sticky : !syncB[i];
    assign reqFlag[i] = rawReq && !encBlock && !hideAll;
  end

  assign code = syncB[ENC_PINS-1:0];
  always_comb begin
    reqLevel = '0;
    if (ctl.encMode && (code != NO_REQ_CODE) && !hideAll)
      reqLevel = NO_REQ_CODE - code;
  end

  assign nmiFall    = prevB[NMI_IDX] && !syncB[NMI_IDX];
  assign nmiBlocked = (standby && ctl.maskAll) || (blockStatus && !ctl.nmiBlockOverride);
  assign nmiAccept  = nmiFall && !nmiBlocked;
endmodule

// File: rtl/extint_sense_top.sv
module extint_sense_top
  import extint_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                manualReset,
  input  logic                standby,
  input  logic                blockStatus,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic [NUM_PINS-1:0] reqClear,
  input  logic [NUM_PINS-1:0] irqPin,
  input  logic                nmiPin,
  output logic [NUM_PINS-1:0] reqFlag,
  output logic [ENC_PINS-1:0] reqLevel,
  output logic                nmiAccept
);
  ctlBus_t ctl;
  logic    nmiSyncLow;

  extint_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .manualReset(manualReset),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .ctl(ctl)
  );

  extint_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .irqPin(irqPin), .nmiPin(nmiPin),
    .reqClear(reqClear), .blockStatus(blockStatus), .standby(standby),
    .reqFlag(reqFlag), .reqLevel(reqLevel), .nmiAccept(nmiAccept),
    .nmiSyncLow(nmiSyncLow)
  );
endmodule

// File: rtl/extint_checker.sv
module extint_checker
  import extint_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                manualReset,
  input logic                standby,
  input logic                blockStatus,
  input logic [REG_W-1:0]    regRdData,
  input logic [NUM_PINS-1:0] reqFlag,
  input logic [ENC_PINS-1:0] reqLevel,
  input logic                nmiAccept,
  input logic                nmiSyncLow
);
  assert_manual_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    manualReset |=> regRdData == RESET_VAL);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[BIT_RSVD] == 1'b0);

  assert_enc_hides_low_pins_R9: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[BIT_ENCMODE] |-> reqFlag[ENC_PINS-1:0] == '0);

  assert_indep_no_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[BIT_ENCMODE] |-> reqLevel == '0);

  assert_mask_all_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[BIT_MASKALL] && nmiSyncLow) |-> (reqFlag == '0 && reqLevel == '0));

  assert_nmi_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    nmiAccept |=> !nmiAccept);

  assert_nmi_block_R11: assert property (@(posedge clk) disable iff (!rstN)
    (blockStatus && !regRdData[BIT_NMIOVR]) |-> !nmiAccept);

  assert_nmi_standby_R12: assert property (@(posedge clk) disable iff (!rstN)
    (standby && regRdData[BIT_MASKALL]) |-> !nmiAccept);
endmodule

bind extint_sense_top extint_checker i_checker (
  .clk(clk), .rstN(rstN), .manualReset(manualReset), .standby(standby),
  .blockStatus(blockStatus), .regRdData(regRdData), .reqFlag(reqFlag),
  .reqLevel(reqLevel), .nmiAccept(nmiAccept), .nmiSyncLow(nmiSyncLow)
);

// File: tb/test_extint_sense_top.sv
module test_extint_sense_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        manualReset = 1'b0;
  logic        standby = 1'b0;
  logic        blockStatus = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [5:0]  reqClear = '0;
  logic [5:0]  irqPin = '1;
  logic        nmiPin = 1'b1;
  logic [5:0]  reqFlag;
  logic [3:0]  reqLevel;
  logic        nmiAccept;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_sense_top i_extint_sense_top (
    .clk(clk), .rstN(rstN), .manualReset(manualReset), .standby(standby),
    .blockStatus(blockStatus), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .reqClear(reqClear), .irqPin(irqPin),
    .nmiPin(nmiPin), .reqFlag(reqFlag), .reqLevel(reqLevel),
    .nmiAccept(nmiAccept)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [15:0] v);
    regWrEn = 1'b1;
    regWrData = v;
    cyc(1);
    regWrEn = 1'b0;
  endtask

  task automatic nmiFallTest(string req, logic expAccept);
    nmiPin = 1'b0;
    cyc(1);
    check(req, 16'(nmiAccept), 16'h0);
    cyc(1);
    check(req, 16'(nmiAccept), 16'(expAccept));
    cyc(1);
    check(req, 16'(nmiAccept), 16'h0);
    nmiPin = 1'b1;
    cyc(3);
  endtask

  task automatic t_reset;
    check("R1 reset value", regRdData, 16'h4000);
    check("R1 reset flags", 16'(reqFlag), 16'h0);
    check("R1 reset level", 16'(reqLevel), 16'h0);
    check("R1 reset nmi", 16'(nmiAccept), 16'h0);
  endtask

  task automatic t_register;
    writeReg(16'hFFFF);
    check("R2 reserved bit12", regRdData, 16'hEFFF);
    writeReg(16'h0000);
    check("R2 write zero", regRdData, 16'h0000);
    writeReg(16'h0A5A);
    standby = 1'b1;
    cyc(4);
    check("R1 standby keeps", regRdData, 16'h0A5A);
    standby = 1'b0;
    manualReset = 1'b1;
    cyc(1);
    manualReset = 1'b0;
    check("R1 manual reset", regRdData, 16'h4000);
  endtask

  task automatic t_falling;
    writeReg(16'h0000);
    irqPin[1] = 1'b0;
    cyc(2);
    check("R3 R4 not yet", 16'(reqFlag), 16'h0);
    cyc(1);
    check("R4 falling set", 16'(reqFlag), 16'h0002);
    irqPin[1] = 1'b1;
    cyc(4);
    check("R4 sticky", 16'(reqFlag), 16'h0002);
    reqClear = 6'b000010;
    cyc(1);
    reqClear = '0;
    check("R7 clear", 16'(reqFlag), 16'h0);
  endtask

  task automatic t_rising;
    writeReg(16'h0010);
    irqPin[2] = 1'b0;
    cyc(4);
    check("R5 no set on fall", 16'(reqFlag), 16'h0);
    irqPin[2] = 1'b1;
    cyc(3);
    check("R5 rising set", 16'(reqFlag), 16'h0004);
    writeReg(16'h0010);
    check("R8 same field keeps", 16'(reqFlag), 16'h0004);
    writeReg(16'h0000);
    check("R8 field change clears", 16'(reqFlag), 16'h0);
  endtask

  task automatic t_level;
    writeReg(16'h0E00);
    irqPin[4] = 1'b0;
    cyc(1);
    check("R3 level one cycle", 16'(reqFlag), 16'h0);
    cyc(1);
    check("R6 level 10 on", 16'(reqFlag), 16'h0010);
    irqPin[4] = 1'b1;
    cyc(2);
    check("R6 level 10 off", 16'(reqFlag), 16'h0);
    irqPin[5] = 1'b0;
    cyc(2);
    check("R6 level 11 on", 16'(reqFlag), 16'h0020);
    irqPin[5] = 1'b1;
    cyc(2);
    check("R6 level 11 off", 16'(reqFlag), 16'h0);
  endtask

  task automatic t_encoded;
    writeReg(16'h4000);
    cyc(2);
    check("R9 code 1111", 16'(reqLevel), 16'h0);
    irqPin[3:0] = 4'b0101;
    cyc(2);
    check("R9 code 0101", 16'(reqLevel), 16'd10);
    irqPin[3:0] = 4'b0000;
    cyc(2);
    check("R9 code 0000", 16'(reqLevel), 16'd15);
    check("R9 low flags hidden", 16'(reqFlag), 16'h0);
    irqPin[3:0] = 4'b1110;
    cyc(3);
    check("R9 code 1110", 16'(reqLevel), 16'd1);
    irqPin[3:0] = 4'b1111;
    cyc(3);
    writeReg(16'h0000);
    cyc(2);
    check("R9 indep level zero", 16'(reqLevel), 16'h0);
    check("R9 indep flags clear", 16'(reqFlag), 16'h0);
  endtask

  task automatic t_maskall;
    writeReg(16'h8800);
    irqPin[5] = 1'b0;
    cyc(2);
    check("R10 before nmi", 16'(reqFlag), 16'h0020);
    nmiPin = 1'b0;
    cyc(2);
    check("R10 masked", 16'(reqFlag), 16'h0);
    nmiPin = 1'b1;
    cyc(2);
    check("R10 unmasked", 16'(reqFlag), 16'h0020);
    writeReg(16'h0800);
    nmiPin = 1'b0;
    cyc(2);
    check("R10 bit15 clear", 16'(reqFlag), 16'h0020);
    nmiPin = 1'b1;
    irqPin[5] = 1'b1;
    cyc(3);
  endtask

  task automatic t_nmi;
    writeReg(16'h0000);
    nmiFallTest("R11 accept", 1'b1);
    blockStatus = 1'b1;
    nmiFallTest("R11 blocked", 1'b0);
    writeReg(16'h2000);
    nmiFallTest("R11 override", 1'b1);
    blockStatus = 1'b0;
    standby = 1'b1;
    writeReg(16'hA000);
    nmiFallTest("R12 standby masked", 1'b0);
    writeReg(16'h2000);
    nmiFallTest("R12 standby bit15 clear", 1'b1);
    standby = 1'b0;
  endtask

  initial begin
    cyc(2);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_register();
    t_falling();
    t_rising();
    t_level();
    t_encoded();
    t_maskall();
    t_nmi();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule